// File: doc/BRIEF.md
# Pairwise-Hierarchical Replacement Engine with Way Locking

This block keeps the replacement history of every set of an 8-way set-associative cache and names the way to evict on a miss. The ways are grouped into four pairs, {0,1}, {2,3}, {4,5} and {6,7}. For each set the block stores a 10-bit record. Six bits hold the exact recency order among the four pairs, one bit for each pair of pairs. Four bits record which member of each pair was used less recently.

Each hit or line fill presents the set index and the way that was touched. One clock later the accessed pair becomes the most recent pair of that set, and the other member of that pair becomes its less recent member. A separate read port takes a set index and a per-way lock mask, which comes from the tag array where lock state lives. The block returns the eviction choice combinationally from the stored record. The choice never falls on a locked way. With at most four ways locked, a choice always exists.

Top module: `hlru_repl`

## Requirements
- R1: After reset every set holds the same initial record, in which pair 0 is the least recent pair and the even way is the less recent member of every pair, so with no locks every set names way 0.
- R2: An access with `acc_valid` high makes the accessed pair the most recent pair of its set from the next cycle on. While at most four ways are locked, no way of that pair is named for that set.
- R3: An access to way w makes its partner way (w XOR 1) the less recent member of the pair.
- R4: The named way is the less recent member of the least recent pair that still has an unlocked way. The order among pairs is exact.
- R5: When the less recent member of the chosen pair is locked, its partner is named.
- R6: A pair whose two ways are both locked is skipped, and the next older pair is considered.
- R7: `vic_ok` is high whenever at least one way is unlocked, and low when all eight bits of `lock_mask` are set. Bit k of `lock_mask` set to 1 means way k is locked.
- R8: While `vic_ok` is high, `vic_way` never names a way whose lock bit is set.
- R9: An access changes only the record of its own set. Inputs presented with `acc_valid` low change no record.
- R10: The eviction output reflects accesses up to the previous clock edge. An access to the set being read, presented in the same cycle, shows up only after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A hit or fill occurred this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 3 | Way that was hit or filled |
| vic_set | input | SET_W | Set index whose eviction choice is requested |
| lock_mask | input | 8 | Per-way lock bits of `vic_set`, 1 = locked |
| vic_way | output | 3 | Way to evict |
| vic_ok | output | 1 | An unlocked way exists in the requested set |

## Verification
The bench builds the block with 8 sets, so `acc_set` and `vic_set` are 3 bits wide and the highest set index is reachable. This lets a test show that activity in one set leaves its neighbours untouched. The pair and member widths are fixed by the 10-bit record format, so every ordering of the four pairs and every lock pattern over the eight ways is reachable with these values. The bench uses that reach to drive a long access sequence through all four pairs. It also drives lock patterns that fully cover one or two pairs, half-lock several pairs, and lock all eight ways.

// File: rtl/hlru_pkg.sv
package hlru_pkg;

    localparam int PAIRS   = 4;
    localparam int WAYS    = 2 * PAIRS;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int PAIR_W  = $clog2(PAIRS);
    localparam int ORD_W   = PAIRS * (PAIRS - 1) / 2;
    localparam int ORD_IW  = $clog2(ORD_W);
    localparam int REC_W   = ORD_W + PAIRS;

    // order bit for pairs (a,b), a<b: 1 means pair a was used more recently than pair b
    // member bit of pair p: 0 means way 2p is the less recent one, 1 means way 2p+1
    typedef struct packed {
        logic [ORD_W-1:0] order;
        logic [PAIRS-1:0] member;
    } repl_t;

    function automatic int ord_idx(input int a, input int b);
        return a * (2 * PAIRS - a - 1) / 2 + (b - a - 1);
    endfunction

    function automatic logic [ORD_IW-1:0] ord_bit(input int a, input int b);
        int k;
        k = ord_idx(a, b);
        return k[ORD_IW-1:0];
    endfunction

    // 1 when pair a is more recent than pair b (a != b)
    function automatic logic pair_newer(input logic [ORD_W-1:0] ord, input int a, input int b);
        if (a < b) return ord[ord_bit(a, b)];
        else       return ~ord[ord_bit(b, a)];
    endfunction

endpackage

// File: rtl/hlru_update.sv
module hlru_update
    import hlru_pkg::*;
(
    input  repl_t             cur,
    input  logic [WAY_W-1:0]  way,
    output repl_t             nxt
);

    logic [PAIR_W-1:0] pair;

    assign pair = way[WAY_W-1:1];

    always_comb begin
        nxt = cur;
        for (int a = 0; a < PAIRS; a++) begin
            for (int b = a + 1; b < PAIRS; b++) begin
                if (a[PAIR_W-1:0] == pair) begin
                    nxt.order[ord_bit(a, b)] = 1'b1;
                end else if (b[PAIR_W-1:0] == pair) begin
                    nxt.order[ord_bit(a, b)] = 1'b0;
                end
            end
        end
        // partner of the touched way becomes the less recent member
        nxt.member[pair] = ~way[0];
    end

endmodule

// File: rtl/hlru_victim.sv
module hlru_victim
    import hlru_pkg::*;
(
    input  repl_t             cur,
    input  logic [WAYS-1:0]   lock,
    output logic [WAY_W-1:0]  vic_way,
    output logic              vic_ok
);

    logic [PAIRS-1:0]  cand;
    logic [PAIRS-1:0]  oldest;
    logic [PAIRS-1:0]  beats [PAIRS];
    logic [PAIR_W-1:0] sel;
    logic              found;
    logic [WAY_W-1:0]  lru_way;
    logic [WAY_W-1:0]  alt_way;

    for (genvar p = 0; p < PAIRS; p++) begin : g_cand
        assign cand[p] = ~(lock[2*p] & lock[2*p+1]);
    end

    // beats[p][q]: pair q does not stop pair p from being the oldest candidate
    for (genvar p = 0; p < PAIRS; p++) begin : g_row
        for (genvar q = 0; q < PAIRS; q++) begin : g_col
            if (p == q) begin : g_self
                assign beats[p][q] = 1'b1;
            end else begin : g_other
                assign beats[p][q] = ~cand[q] | pair_newer(cur.order, q, p);
            end
        end
        assign oldest[p] = cand[p] & (&beats[p]);
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int p = 0; p < PAIRS; p++) begin
            if (oldest[p[PAIR_W-1:0]] && !found) begin
                found = 1'b1;
                sel   = p[PAIR_W-1:0];
            end
        end
    end

    assign lru_way = {sel, cur.member[sel]};
    assign alt_way = {sel, ~cur.member[sel]};
    assign vic_way = lock[lru_way] ? alt_way : lru_way;
    assign vic_ok  = |cand;

endmodule

// File: rtl/hlru_store.sv
module hlru_store
    import hlru_pkg::*;
#(
    parameter  int NUM_SETS = 32,
    localparam int SET_W    = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  repl_t             wr_rec,
    input  logic [SET_W-1:0]  rd_a_set,
    output repl_t             rd_a_rec,
    input  logic [SET_W-1:0]  rd_b_set,
    output repl_t             rd_b_rec
);

    typedef struct packed {
        repl_t [NUM_SETS-1:0] tbl;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tbl[wr_set] = wr_rec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_rec = st_q.tbl[rd_a_set];
    assign rd_b_rec = st_q.tbl[rd_b_set];

endmodule

// File: rtl/hlru_repl.sv
module hlru_repl
    import hlru_pkg::*;
#(
    parameter  int NUM_SETS = 32,
    localparam int SET_W    = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic [WAY_W-1:0]  acc_way,
    input  logic [SET_W-1:0]  vic_set,
    input  logic [WAYS-1:0]   lock_mask,
    output logic [WAY_W-1:0]  vic_way,
    output logic              vic_ok
);

    repl_t acc_rec;
    repl_t acc_nxt;
    repl_t vic_rec;

    hlru_store #(.NUM_SETS(NUM_SETS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_valid),
        .wr_set   (acc_set),
        .wr_rec   (acc_nxt),
        .rd_a_set (acc_set),
        .rd_a_rec (acc_rec),
        .rd_b_set (vic_set),
        .rd_b_rec (vic_rec)
    );

    hlru_update u_update (
        .cur (acc_rec),
        .way (acc_way),
        .nxt (acc_nxt)
    );

    hlru_victim u_victim (
        .cur     (vic_rec),
        .lock    (lock_mask),
        .vic_way (vic_way),
        .vic_ok  (vic_ok)
    );

endmodule

// File: rtl/hlru_repl_chk.sv
module hlru_repl_chk
    import hlru_pkg::*;
#(
    parameter  int NUM_SETS = 32,
    localparam int SET_W    = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic [WAY_W-1:0]  acc_way,
    input  logic [SET_W-1:0]  vic_set,
    input  logic [WAYS-1:0]   lock_mask,
    input  logic [WAY_W-1:0]  vic_way,
    input  logic              vic_ok
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_OK_WHEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lock_mask) <= PAIRS) |-> vic_ok);                          // R7

    AST_NONE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (&lock_mask) |-> !vic_ok);                                             // R7

    AST_VIC_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        vic_ok |-> !lock_mask[vic_way]);                                       // R8

    AST_FRESH_PAIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(acc_valid) && (vic_set == $past(acc_set))
         && ($countones(lock_mask) <= PAIRS))
        |-> (vic_way[WAY_W-1:1] != $past(acc_way[WAY_W-1:1])));                // R2

endmodule

bind hlru_repl hlru_repl_chk #(.NUM_SETS(NUM_SETS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_set   (acc_set),
    .acc_way   (acc_way),
    .vic_set   (vic_set),
    .lock_mask (lock_mask),
    .vic_way   (vic_way),
    .vic_ok    (vic_ok)
);

// File: tb/hlru_repl_test.sv
module hlru_repl_test;

    localparam int PERIOD   = 10;
    localparam int NSETS    = 8;
    localparam int SW       = $clog2(NSETS);
    localparam int TBL_N    = 10;

    // {way touched on set 3, lock mask then applied, expected eviction way}
    localparam logic [13:0] TBL [TBL_N] = '{
        {3'd0, 8'h00, 3'd2},
        {3'd3, 8'h00, 3'd4},
        {3'd4, 8'h00, 3'd6},
        {3'd7, 8'h00, 3'd1},
        {3'd1, 8'h04, 3'd3},
        {3'd5, 8'h0C, 3'd6},
        {3'd6, 8'h0F, 3'd4},
        {3'd2, 8'hF0, 3'd0},
        {3'd0, 8'h10, 3'd5},
        {3'd5, 8'hC8, 3'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic [2:0]    acc_way = '0;
    logic [SW-1:0] vic_set = '0;
    logic [7:0]    lock_mask = '0;
    logic [2:0]    vic_way;
    logic          vic_ok;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    hlru_repl #(.NUM_SETS(NSETS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_set   (acc_set),
        .acc_way   (acc_way),
        .vic_set   (vic_set),
        .lock_mask (lock_mask),
        .vic_way   (vic_way),
        .vic_ok    (vic_ok)
    );

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic touch(input logic [SW-1:0] s, input logic [2:0] w);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_set   = s;
        acc_way   = w;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic peek(input logic [SW-1:0] s, input logic [7:0] lk);
        vic_set   = s;
        lock_mask = lk;
        #1;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: initial record of every set names way 0
        for (int s = 0; s < NSETS; s++) begin
            peek(s[SW-1:0], 8'h00);
            chk("R1 reset way", {1'b0, vic_way}, 4'd0);
            chk("R7 reset ok", {3'b0, vic_ok}, 4'd1);
        end

        // R4 R3 R5 R6: table walk on set 3
        for (int i = 0; i < TBL_N; i++) begin
            touch(3'd3, TBL[i][13:11]);
            peek(3'd3, TBL[i][10:3]);
            chk($sformatf("R4 table step %0d", i), {1'b0, vic_way}, {1'b0, TBL[i][2:0]});
        end

        // R9: set 4 untouched by the table walk
        peek(3'd4, 8'h00);
        chk("R9 neighbour set", {1'b0, vic_way}, 4'd0);

        // R9: strobe with acc_valid low has no effect
        @(negedge clk);
        acc_set = 3'd6; acc_way = 3'd0; acc_valid = 1'b0;
        @(negedge clk);
        peek(3'd6, 8'h00);
        chk("R9 invalid access ignored", {1'b0, vic_way}, 4'd0);

        // R5: fresh set, even ways locked -> partner of way 0
        peek(3'd6, 8'h55);
        chk("R5 partner of locked member", {1'b0, vic_way}, 4'd1);
        // R6: pairs 0 and 1 fully locked -> pair 2, way 4
        peek(3'd6, 8'h0F);
        chk("R6 skip locked pairs", {1'b0, vic_way}, 4'd4);
        // R7: all locked
        peek(3'd6, 8'hFF);
        chk("R7 none free", {3'b0, vic_ok}, 4'd0);

        // R2: touch way 0 of fresh set 2, pair 0 no longer chosen
        touch(3'd2, 3'd0);
        peek(3'd2, 8'h00);
        chk("R2 accessed pair newest", {1'b0, vic_way}, 4'd2);

        // R3: touch 1,3,5,7 on set 7 -> way 0 is the less recent member of pair 0
        touch(3'd7, 3'd1); touch(3'd7, 3'd3); touch(3'd7, 3'd5); touch(3'd7, 3'd7);
        peek(3'd7, 8'h00);
        chk("R3 partner after odd touch", {1'b0, vic_way}, 4'd0);
        touch(3'd7, 3'd0); touch(3'd7, 3'd3); touch(3'd7, 3'd5); touch(3'd7, 3'd7);
        peek(3'd7, 8'h00);
        chk("R3 partner after even touch", {1'b0, vic_way}, 4'd1);

        // R10: same-cycle access shows after the edge only
        @(negedge clk);
        acc_valid = 1'b1; acc_set = 3'd5; acc_way = 3'd0;
        peek(3'd5, 8'h00);
        chk("R10 before edge", {1'b0, vic_way}, 4'd0);
        @(negedge clk);
        acc_valid = 1'b0;
        peek(3'd5, 8'h00);
        chk("R10 after edge", {1'b0, vic_way}, 4'd2);

        // R1: reset mid-run restores the initial record
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        peek(3'd3, 8'h00);
        chk("R1 reset after use", {1'b0, vic_way}, 4'd0);
        peek(3'd5, 8'h00);
        chk("R1 reset after use set 5", {1'b0, vic_way}, 4'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule